// File: doc/BRIEF.md
# Predicated Tile Broadcast-Add Accumulator

This block keeps a square accumulator store and performs one operation on it: each element of an incoming source vector is added to every selected element of the matching row of a chosen tile. Two byte-granular masks decide which elements take part. The row mask is indexed by the tile row, and the column mask is indexed by the element position within the row. The store can be viewed as tiles of 32-bit elements or tiles of 64-bit elements. Both views share the same bits.

With vector length `VLEN` (default 128), the store has `VLEN/8` rows of `VLEN` bits each. A tile of element width `E` holds `D = VLEN/E` rows of `D` elements. There are `E/8` tiles of that width, interleaved through the store. A caller sets the element width, tile index, source vector and both masks, and then pulses `start` for one cycle. The store is written at that clock edge, and `done` is high during the following cycle. Any store row can be read at any time through a combinational read port.

Top module: `tile_bcast_acc`

## Requirements
- R1: After reset every bit of every store row reads zero and `done` is low.
- R2: Row r of tile t lives in store row r*(E/8)+t, where `esz`=0 selects E=32 and `esz`=1 selects E=64. Column c of a tile row occupies bits [c*E +: E] of that store row.
- R3: With E=32, source element r (`src[r*32 +: 32]`) is added to every active element of row r of the selected tile.
- R4: With E=64, source element r (`src[r*64 +: 64]`) is added to every active element of row r of the selected tile.
- R5: Element (r,c) is active exactly when `pn[r*(E/8)]` and `pm[c*(E/8)]` are both 1. All other mask bits have no effect.
- R6: An inactive element of the selected tile keeps its value.
- R7: Each sum wraps modulo 2^E. No carry passes between neighbouring elements.
- R8: With E=32 only `tile[1:0]` selects the tile, and `tile[2]` is ignored. With E=64 all three bits select one of 8 tiles.
- R9: The new contents are visible on the read port in the cycle after the `start` edge. `done` is high for exactly that one cycle per `start` pulse.
- R10: Store rows that do not belong to the selected tile are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts one broadcast-add, sampled at the rising edge |
| esz | input | 1 | Element width: 0 = 32 bit, 1 = 64 bit |
| tile | input | 3 | Tile index |
| src | input | VLEN | Source vector |
| pn | input | VLEN/8 | Row mask, one bit per byte |
| pm | input | VLEN/8 | Column mask, one bit per byte |
| rd_sel | input | log2(VLEN/8) | Store row to read |
| rd_row | output | VLEN | Contents of the selected store row |
| done | output | 1 | One-cycle pulse after an operation |

## Verification
Any corrupted element in the store stays there. It appears on `rd_row` as soon as its row is selected, starting in the cycle right after the faulty write. A wrong mapping of tile index to store row shows up at once as a change in a foreign row. A mask bit taken from the wrong position shows up as an element that was updated or skipped against the two-mask rule. Carries that leak between lanes, and sums that saturate instead of wrapping, appear in the first addition that overflows an element. For that reason, the bench reads back all store rows after every operation.

// File: rtl/tile_acc_pkg.sv
package tile_acc_pkg;
    typedef enum logic {
        ESZ_W32 = 1'b0,
        ESZ_W64 = 1'b1
    } esz_e;
endpackage

// File: rtl/tile_pred_decode.sv
// Turns the byte-granular masks into per-row and per-32-bit-lane enables.
module tile_pred_decode #(
    parameter int unsigned VLEN = 128
) (
    input  logic                   esz,
    input  logic [VLEN/8-1:0]      pn,
    input  logic [VLEN/8-1:0]      pm,
    output logic [VLEN/32-1:0]     row_act,
    output logic [VLEN/32-1:0]     lane_en
);
    localparam int unsigned DIM_MAX = VLEN / 32;
    localparam int unsigned DIM64   = VLEN / 64;

    for (genvar r = 0; r < DIM_MAX; r++) begin : g_row
        if (r < DIM64) begin : g_both
            assign row_act[r] = esz ? pn[r*8] : pn[r*4];
        end else begin : g_w32_only
            assign row_act[r] = esz ? 1'b0 : pn[r*4];
        end
    end

    for (genvar l = 0; l < DIM_MAX; l++) begin : g_lane
        assign lane_en[l] = esz ? pm[(l/2)*8] : pm[l*4];
    end

    // Rows beyond the 64-bit tile height can never be enabled in 64-bit mode (R4)
    always_comb begin
        assert_no_row_beyond_dim_R4: assert (!(esz && (row_act >> DIM64) != '0));
    end
endmodule

// File: rtl/tile_row_adder.sv
// Adds one broadcast element to every enabled lane of a store row.
module tile_row_adder #(
    parameter int unsigned VLEN = 128
) (
    input  logic                   esz,
    input  logic [VLEN-1:0]        old_row,
    input  logic [63:0]            elem,
    input  logic [VLEN/32-1:0]     lane_en,
    output logic [VLEN-1:0]        new_row
);
    localparam int unsigned L32 = VLEN / 32;
    localparam int unsigned L64 = VLEN / 64;

    logic [L32-1:0][31:0] sum32;
    logic [L64-1:0][63:0] sum64;

    for (genvar l = 0; l < L32; l++) begin : g_s32
        assign sum32[l] = old_row[l*32 +: 32] + elem[31:0];
    end

    for (genvar k = 0; k < L64; k++) begin : g_s64
        assign sum64[k] = old_row[k*64 +: 64] + elem;
    end

    for (genvar l = 0; l < L32; l++) begin : g_sel
        always_comb begin
            if (!lane_en[l]) begin
                new_row[l*32 +: 32] = old_row[l*32 +: 32];
            end else if (esz) begin
                new_row[l*32 +: 32] = sum64[l/2][(l%2)*32 +: 32];
            end else begin
                new_row[l*32 +: 32] = sum32[l];
            end
        end
    end
endmodule

// File: rtl/tile_bcast_acc.sv
module tile_bcast_acc #(
    parameter int unsigned VLEN = 128
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          esz,
    input  logic [2:0]                    tile,
    input  logic [VLEN-1:0]               src,
    input  logic [VLEN/8-1:0]             pn,
    input  logic [VLEN/8-1:0]             pm,
    input  logic [$clog2(VLEN/8)-1:0]     rd_sel,
    output logic [VLEN-1:0]               rd_row,
    output logic                          done
);
    import tile_acc_pkg::*;

    localparam int unsigned NROWS   = VLEN / 8;
    localparam int unsigned RW      = $clog2(NROWS);
    localparam int unsigned DIM_MAX = VLEN / 32;
    localparam int unsigned DIM64   = VLEN / 64;

    typedef struct packed {
        logic [NROWS-1:0][VLEN-1:0] za;
        logic                       done;
    } st_t;

    st_t st_d, st_q;

    esz_e                          mode;
    logic [DIM_MAX-1:0]            row_act;
    logic [DIM_MAX-1:0]            lane_en;
    logic [DIM_MAX-1:0][RW-1:0]    tgt;
    logic [DIM_MAX-1:0][63:0]      elem;
    logic [DIM_MAX-1:0][VLEN-1:0]  new_row;

    assign mode = esz_e'(esz);

    tile_pred_decode #(.VLEN(VLEN)) u_pred (
        .esz     (esz),
        .pn      (pn),
        .pm      (pm),
        .row_act (row_act),
        .lane_en (lane_en)
    );

    for (genvar r = 0; r < DIM_MAX; r++) begin : g_trow
        localparam int unsigned BASE32 = r * 4;
        localparam int unsigned BASE64 = r * 8;
        if (r < DIM64) begin : g_both
            assign tgt[r]  = (mode == ESZ_W64) ? RW'(BASE64) + RW'(tile)
                                               : RW'(BASE32) + RW'(tile[1:0]);
            assign elem[r] = (mode == ESZ_W64) ? src[r*64 +: 64]
                                               : {32'b0, src[r*32 +: 32]};
        end else begin : g_w32_only
            assign tgt[r]  = RW'(BASE32) + RW'(tile[1:0]);
            assign elem[r] = {32'b0, src[r*32 +: 32]};
        end

        tile_row_adder #(.VLEN(VLEN)) u_add (
            .esz     (esz),
            .old_row (st_q.za[tgt[r]]),
            .elem    (elem[r]),
            .lane_en (lane_en),
            .new_row (new_row[r])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = start;
        if (start) begin
            for (int r = 0; r < DIM_MAX; r++) begin
                if (row_act[r]) begin
                    st_d.za[tgt[r]] = new_row[r];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_row = st_q.za[rd_sel];
    assign done   = st_q.done;

    assert_done_follows_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    assert_no_spurious_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    assert_empty_row_mask_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && pn == '0) |=> $stable(st_q.za));

    assert_empty_col_mask_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && pm == '0) |=> $stable(st_q.za));

    for (genvar i = 0; i < NROWS; i++) begin : g_chk
        assert_foreign_row_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (start && (esz ? (tile != 3'(i % 8)) : (tile[1:0] != 2'(i % 4))))
            |=> $stable(st_q.za[i]));
    end
endmodule

// File: tb/tile_bcast_acc_test.sv
`timescale 1ns/1ps
module tile_bcast_acc_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         esz = 1'b0;
    logic [2:0]   tile = '0;
    logic [127:0] src = '0;
    logic [15:0]  pn = '0;
    logic [15:0]  pm = '0;
    logic [3:0]   rd_sel = '0;
    logic [127:0] rd_row;
    logic         done;

    int total = 0;
    int bad = 0;
    logic [127:0] mdl [16];

    always #2 clk = ~clk;

    tile_bcast_acc #(.VLEN(128)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .esz(esz), .tile(tile),
        .src(src), .pn(pn), .pm(pm), .rd_sel(rd_sel), .rd_row(rd_row), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Reference model written from R2-R8
    task automatic model_apply(input logic e, input logic [2:0] t, input logic [127:0] s,
                               input logic [15:0] a, input logic [15:0] b);
        int nt  = e ? 8 : 4;
        int dim = e ? 2 : 4;
        int tt  = e ? int'(t) : int'(t[1:0]);
        for (int r = 0; r < dim; r++) begin
            for (int c = 0; c < dim; c++) begin
                if (a[r*nt] && b[c*nt]) begin
                    if (e) mdl[r*nt+tt][c*64 +: 64] = mdl[r*nt+tt][c*64 +: 64] + s[r*64 +: 64];
                    else   mdl[r*nt+tt][c*32 +: 32] = mdl[r*nt+tt][c*32 +: 32] + s[r*32 +: 32];
                end
            end
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 16; i++) begin
            rd_sel = 4'(i);
            #0.5;
            chk(rd_row === mdl[i], $sformatf("%s row%0d", req, i), rd_row, mdl[i]);
        end
    endtask

    task automatic do_op(input logic e, input logic [2:0] t, input logic [127:0] s,
                         input logic [15:0] a, input logic [15:0] b, input string req);
        @(negedge clk);
        esz = e; tile = t; src = s; pn = a; pm = b; start = 1'b1;
        @(negedge clk);
        chk(done === 1'b1, "R9 done high after start", 128'(done), 128'(1));
        start = 1'b0;
        model_apply(e, t, s, a, b);
        check_all({req, " R9 R10"});
        @(negedge clk);
        chk(done === 1'b0, "R9 done single cycle", 128'(done), 128'(0));
    endtask

    task automatic t_reset;
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(done === 1'b0, "R1 done after reset", 128'(done), 128'(0));
        check_all("R1");
    endtask

    task automatic t_full32;
        do_op(1'b0, 3'd1, {32'h4, 32'h3, 32'h2, 32'h1}, 16'hFFFF, 16'hFFFF, "R3 R2 full32");
        do_op(1'b0, 3'd1, {32'h40, 32'h30, 32'h20, 32'h10}, 16'hFFFF, 16'hFFFF, "R3 accumulate");
    endtask

    task automatic t_mask32;
        // rows 0,2 and cols 1,3 active; noise on non-lowest byte bits (R5, R6)
        do_op(1'b0, 3'd0, {32'hD, 32'hC, 32'hB, 32'hA}, 16'b1110_0001_1110_0001,
              16'b0001_1110_0001_1110, "R5 R6 mask32");
        do_op(1'b0, 3'd3, 128'h1111_2222_3333_4444_5555_6666_7777_8888, 16'hEEEE, 16'hFFFF,
              "R5 noise-only rows");
    endtask

    task automatic t_full64;
        do_op(1'b1, 3'd5, {64'h0000_0001_0000_0000, 64'h0000_0000_FFFF_FFFF}, 16'hFFFF, 16'hFFFF,
              "R4 full64");
        do_op(1'b1, 3'd2, {64'h99, 64'h77}, 16'h0100, 16'h00FF, "R4 R5 mask64");
    endtask

    task automatic t_wrap;
        do_op(1'b0, 3'd2, {4{32'hFFFF_FFFF}}, 16'hFFFF, 16'hFFFF, "R7 prime32");
        do_op(1'b0, 3'd2, {4{32'h0000_0002}}, 16'hFFFF, 16'hFFFF, "R7 wrap32");
        do_op(1'b1, 3'd7, {2{64'hFFFF_FFFF_FFFF_FFFF}}, 16'hFFFF, 16'hFFFF, "R7 prime64");
        do_op(1'b1, 3'd7, {2{64'h0000_0000_0000_0003}}, 16'hFFFF, 16'hFFFF, "R7 wrap64");
    endtask

    task automatic t_tilebit;
        do_op(1'b0, 3'b110, {32'h5, 32'h6, 32'h7, 32'h8}, 16'hFFFF, 16'hFFFF, "R8 tile bit2 ignored");
        do_op(1'b1, 3'b110, {64'h21, 64'h12}, 16'hFFFF, 16'hFFFF, "R8 tile 6 in 64");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_full32();
        t_mask32();
        t_full64();
        t_wrap();
        t_tilebit();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule